// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lets a bus host read and write a 128-byte register space through an internal byte pointer. It filters and synchronizes SCL and SDA onto the system clock and recognises START, repeated START and STOP. It answers only its fixed 7-bit address. In a write transfer the first byte after the address is a command that loads the pointer. It supports four transfer shapes: a single-byte write; a quick read, which has no command and returns the byte at the current pointer; a single-byte read, made of a command, a repeated START and one byte; and an incremental read, in which bytes follow one another until the host NACKs.

Reads that start on an even address fetch the even byte and its odd neighbour in one register-file access. The odd byte is then served from that snapshot, so a 16-bit quantity stays consistent across its two bytes. The block refuses some accesses by answering with a NACK: a command outside the register space, a data byte aimed at a read-only byte, and any write data byte after the first. If the bus sits low without SCL activity for a set number of system clocks, the block lets go of SDA and returns to idle.

The register-file side is a plain synchronous port and has no back-pressure. A read strobe returns a byte pair on the following clock, and a write strobe is always taken in the cycle it is given. The bus side cannot be stalled either, because the block never stretches SCL. A register file attached to the port must therefore keep to the fixed one-cycle read latency.

Top module: `i2c_reg_target`

## Requirements
- R1: Only the 7-bit address 0x55 (byte 0xAA for write, 0xAB for read) is ACKed. After any other address the block stays silent, ACKs nothing and issues no strobe until the next START.
- R2: A write transfer of address, command and one data byte ACKs all three bytes. It produces exactly one `reg_wr_en` pulse, carrying the command as `reg_addr` and the data byte as `reg_wdata`.
- R3: The pointer moves one step past every byte written and past every byte read from an odd address. A quick read returns the byte at the current pointer.
- R4: A command, a repeated START and a read return the byte at the address given by the command.
- R5: A read from an even address makes a single `reg_rd_en` access. It returns the even byte, and when the host ACKs it, returns the odd byte captured in that same access, even if the register changed in between. The pointer advances by two.
- R6: An incremental read that passes address 0x7F continues at address 0x00.
- R7: A command byte of 0x80 or more is NACKed.
- R8: A data byte written to an address flagged in the read-only mask is NACKed, and no write strobe is issued, so the register keeps its value.
- R9: In a write transfer, each data byte after the first is NACKed and produces no write strobe.
- R10: When SCL or SDA stays low with no SCL edge for `STUCK_CYCLES` system clocks, the block releases SDA in the next cycle and waits for a new START.
- R11: The block starts pulling SDA low only while SCL is low.
- R12: After reset SDA is released, and neither `reg_wr_en` nor `reg_rd_en` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | When high, the SDA line is pulled low |
| reg_addr | output | 8 | Register address for a read or a write strobe |
| reg_rd_en | output | 1 | Read strobe; `reg_rdata` must be valid on the next clock |
| reg_rdata | input | 16 | Bits 7:0 are the byte at `reg_addr`; bits 15:8 are the byte at `reg_addr`+1, modulo the depth |
| reg_wr_en | output | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | output | 8 | Write data |

## Verification
The bound checker watches four things on every cycle. SDA is let go in the cycle after the stuck-bus timeout. The block never begins pulling SDA low while its synchronized SCL is high. Read and write strobes are single-cycle and never overlap. No write strobe ever targets a read-only address. Which bytes come back, the pointer moves, the snapshot of the odd byte, the wrap at 0x7F, and the ACK/NACK pattern of each refused access depend on whole transfers, so only the directed bus scenarios in the bench can show them.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_HOLD
  } tgt_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_i,
  input  logic     sda_i,
  output logic     scl_s,
  output logic     sda_s,
  output bus_evt_t evt
);

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic                   scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ff[SYNC_STAGES-1];
      sda_q  <= sda_ff[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign evt.rise  = scl_s & ~scl_q;
  assign evt.fall  = ~scl_s & scl_q;
  assign evt.start = scl_s & scl_q & sda_q & ~sda_s;
  assign evt.stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_stuck_timer.sv
module i2c_stuck_timer #(
  parameter int LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_edge,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          fired;

  assign expired = (cnt == CW'(LIMIT)) && !fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else if (scl_edge || (scl_s && sda_s)) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
      if (expired) fired <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_read_stager.sv
module i2c_read_stager #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch,
  input  logic [AW-1:0]   fetch_addr,
  input  logic [2*DW-1:0] rd_data,
  output logic            rd_en,
  output logic [AW-1:0]   rd_addr,
  output logic [2*DW-1:0] pair
);

  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en   <= 1'b0;
      rd_addr <= '0;
      pend    <= 1'b0;
      pair    <= '0;
    end else begin
      rd_en <= fetch;
      pend  <= rd_en;
      if (fetch) rd_addr <= fetch_addr;
      if (pend)  pair    <= rd_data;
    end
  end

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]           TARGET_ADDR  = 7'h55,
  parameter int                   REG_DEPTH    = 128,
  parameter int                   STUCK_CYCLES = 2000,
  parameter logic [REG_DEPTH-1:0] RO_MASK      = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [7:0]  reg_addr,
  output logic        reg_rd_en,
  input  logic [15:0] reg_rdata,
  output logic        reg_wr_en,
  output logic [7:0]  reg_wdata
);

  localparam int PW = $clog2(REG_DEPTH);
  localparam int AW = 8;
  localparam int DW = 8;

  logic       scl_s, sda_s, bus_timeout;
  bus_evt_t   evt;
  tgt_state_e state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx, odd_byte;
  logic [PW-1:0] ptr;
  logic       rw, ack_drv, first_wr, host_ack, have_odd;
  logic       fetch_q;
  logic [AW-1:0] wr_addr_q, rd_addr;
  logic [2*DW-1:0] pair;

  i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .evt(evt)
  );

  i2c_stuck_timer #(.LIMIT(STUCK_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_edge(evt.rise | evt.fall), .expired(bus_timeout)
  );

  i2c_read_stager #(.AW(AW), .DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n), .fetch(fetch_q), .fetch_addr(AW'(ptr)),
    .rd_data(reg_rdata), .rd_en(reg_rd_en), .rd_addr(rd_addr), .pair(pair)
  );

  // Decode of the byte just shifted in and of read progress
  logic byte_done, addr_hit, cmd_ok, wr_accept, set_ptr, load_byte;
  logic tx_shift, fetch_now, clear_odd;

  assign byte_done = evt.fall && (bitcnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == TARGET_ADDR);
  assign cmd_ok    = (int'(shreg) < REG_DEPTH);
  assign wr_accept = (state == ST_WDATA) && byte_done && first_wr && !RO_MASK[ptr];
  assign set_ptr   = (state == ST_CMD) && byte_done && cmd_ok;
  assign load_byte = evt.fall && (((state == ST_ADDR_ACK) && rw) ||
                                  ((state == ST_RDATA_ACK) && host_ack));
  assign tx_shift  = (state == ST_RDATA) && evt.fall && (bitcnt != 4'd7);
  assign fetch_now = ((state == ST_ADDR) && byte_done && addr_hit && shreg[0]) ||
                     ((state == ST_RDATA) && evt.fall && (bitcnt == 4'd7) && !have_odd);
  assign clear_odd = evt.start || evt.stop || bus_timeout;

  // Protocol sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      rw       <= 1'b0;
      ack_drv  <= 1'b0;
      first_wr <= 1'b0;
      host_ack <= 1'b0;
    end else if (bus_timeout || evt.stop) begin
      state   <= ST_IDLE;
      ack_drv <= 1'b0;
    end else if (evt.start) begin
      state   <= ST_ADDR;
      bitcnt  <= '0;
      ack_drv <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (evt.rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end
          if (byte_done) begin
            if (state == ST_ADDR) begin
              rw      <= shreg[0];
              ack_drv <= addr_hit;
              state   <= addr_hit ? ST_ADDR_ACK : ST_HOLD;
            end else if (state == ST_CMD) begin
              ack_drv <= cmd_ok;
              state   <= cmd_ok ? ST_CMD_ACK : ST_HOLD;
            end else begin
              ack_drv  <= wr_accept;
              first_wr <= 1'b0;
              state    <= ST_WDATA_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (evt.fall) begin
          ack_drv  <= 1'b0;
          bitcnt   <= '0;
          first_wr <= 1'b1;
          state    <= rw ? ST_RDATA : ST_CMD;
        end
        ST_CMD_ACK, ST_WDATA_ACK: if (evt.fall) begin
          ack_drv <= 1'b0;
          bitcnt  <= '0;
          state   <= ST_WDATA;
        end
        ST_RDATA: if (evt.fall) begin
          if (bitcnt == 4'd7) begin
            bitcnt <= '0;
            state  <= ST_RDATA_ACK;
          end else begin
            bitcnt <= bitcnt + 4'd1;
          end
        end
        ST_RDATA_ACK: begin
          if (evt.rise) host_ack <= ~sda_s;
          if (evt.fall) state <= host_ack ? ST_RDATA : ST_HOLD;
        end
        default: ;
      endcase
    end
  end

  // Pointer, transmit byte, odd-byte snapshot and write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      tx        <= 8'hFF;
      odd_byte  <= '0;
      have_odd  <= 1'b0;
      fetch_q   <= 1'b0;
      reg_wr_en <= 1'b0;
      wr_addr_q <= '0;
      reg_wdata <= '0;
    end else begin
      fetch_q   <= fetch_now;
      reg_wr_en <= wr_accept;
      if (wr_accept) begin
        wr_addr_q <= AW'(ptr);
        reg_wdata <= shreg;
        ptr       <= ptr + PW'(1);
      end
      if (set_ptr) ptr <= shreg[PW-1:0];
      if (tx_shift) tx <= {tx[6:0], 1'b1};
      if (clear_odd) begin
        have_odd <= 1'b0;
      end else if (load_byte) begin
        if (have_odd) begin
          tx       <= odd_byte;
          have_odd <= 1'b0;
        end else begin
          tx <= pair[7:0];
          if (!ptr[0]) begin
            odd_byte <= pair[15:8];
            have_odd <= 1'b1;
            ptr      <= ptr + PW'(2);
          end else begin
            ptr <= ptr + PW'(1);
          end
        end
      end
    end
  end

  assign reg_addr = reg_wr_en ? wr_addr_q : rd_addr;
  assign sda_oe   = (ack_drv && (state == ST_ADDR_ACK || state == ST_CMD_ACK ||
                                 state == ST_WDATA_ACK)) ||
                    ((state == ST_RDATA) && !tx[7]);

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int                   REG_DEPTH = 128,
  parameter logic [REG_DEPTH-1:0] RO_MASK   = '0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       bus_timeout,
  input logic       sda_oe,
  input logic       reg_wr_en,
  input logic       reg_rd_en,
  input logic [7:0] reg_addr
);

  localparam int PW = $clog2(REG_DEPTH);

  a_r10_release_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    bus_timeout |=> !sda_oe);

  a_r11_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  a_r8_no_readonly_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> !RO_MASK[reg_addr[PW-1:0]]);

  a_r2_write_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  a_r5_fetch_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);

  a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_en && reg_wr_en));

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.REG_DEPTH(REG_DEPTH), .RO_MASK(RO_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .bus_timeout(bus_timeout),
  .sda_oe(sda_oe), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr)
);

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
module tb_i2c_reg_target;

  localparam int H     = 20;
  localparam int STUCK = 400;
  localparam logic [127:0] RO = 128'h3 << 64;   // 0x40 and 0x41 read-only

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe, reg_rd_en, reg_wr_en;
  logic [7:0] reg_addr, reg_wdata;
  logic [15:0] reg_rdata = '0;
  logic sda_line;

  always #5 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  i2c_reg_target #(.STUCK_CYCLES(STUCK), .RO_MASK(RO)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata)
  );

  // Register-file model owned by the bench
  logic [7:0] mem [128];
  int wr_count = 0, rd_count = 0;
  logic poke = 1'b0;
  logic [6:0] poke_addr = '0;
  logic [7:0] poke_data = '0;

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction

  initial for (int i = 0; i < 128; i++) mem[i] = init_val(i);

  always @(posedge clk) begin
    if (reg_wr_en) begin
      mem[reg_addr[6:0]] <= reg_wdata;
      wr_count <= wr_count + 1;
    end
    if (poke) mem[poke_addr] <= poke_data;
    if (reg_rd_en) begin
      reg_rdata <= {mem[7'(reg_addr[6:0] + 7'd1)], mem[reg_addr[6:0]]};
      rd_count  <= rd_count + 1;
    end
  end

  int n_checks = 0, n_fail = 0;
  int drive_viol = 0;
  logic oe_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_h) drive_viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; hold(H);
    scl_h = 1'b1; hold(H);
    sda_h = 1'b0; hold(H);
    scl_h = 1'b0;
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; hold(H);
    scl_h = 1'b1; hold(H);
    sda_h = 1'b1; hold(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; hold(H);
      scl_h = 1'b1; hold(H);
      scl_h = 1'b0;
    end
    sda_h = 1'b1; hold(H);
    scl_h = 1'b1; hold(H/2);
    ack = !sda_line; hold(H/2);
    scl_h = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sda_h = 1'b1; hold(H);
      scl_h = 1'b1; hold(H/2);
      b = {b[6:0], sda_line}; hold(H/2);
      scl_h = 1'b0;
    end
    sda_h = !give_ack; hold(H);
    scl_h = 1'b1; hold(H);
    scl_h = 1'b0;
  endtask

  task automatic set_reg(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); poke_addr = a; poke_data = d; poke = 1'b1;
    @(negedge clk); poke = 1'b0;
  endtask

  task automatic read_one(input logic [7:0] cmd, output logic [7:0] d);
    bit ack;
    bus_start(); send_byte(8'hAA, ack); send_byte(cmd, ack);
    bus_start(); send_byte(8'hAB, ack);
    recv_byte(1'b0, d); bus_stop();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R12 sda released", sda_oe, 0);
    check(reg_wr_en == 1'b0, "R12 no write strobe", reg_wr_en, 0);
    check(reg_rd_en == 1'b0, "R12 no read strobe", reg_rd_en, 0);
  endtask

  task automatic t_addr_mismatch();
    bit ack; int w0 = wr_count;
    bus_start(); send_byte(8'hA8, ack);
    check(!ack, "R1 foreign address NACK", ack, 0);
    send_byte(8'hAA, ack);
    check(!ack, "R1 ignored until START", ack, 0);
    bus_stop();
    check(wr_count == w0, "R1 no strobe", wr_count - w0, 0);
  endtask

  task automatic t_write();
    bit a0, a1, a2; int w0 = wr_count;
    bus_start(); send_byte(8'hAA, a0); send_byte(8'h20, a1); send_byte(8'hC3, a2); bus_stop();
    check(a0 && a1 && a2, "R1 R2 all ACKed", {a0, a1, a2}, 7);
    check(wr_count == w0 + 1, "R2 one write", wr_count - w0, 1);
    check(mem[8'h20] == 8'hC3, "R2 write data", mem[8'h20], 8'hC3);
  endtask

  task automatic t_quick_read();
    bit ack; logic [7:0] d;
    bus_start(); send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop();
    check(d == init_val(8'h21), "R3 quick read after write", d, init_val(8'h21));
    bus_start(); send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop();
    check(d == init_val(8'h22), "R3 pointer +1 after odd read", d, init_val(8'h22));
    bus_start(); send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop();
    check(d == init_val(8'h24), "R5 pointer +2 after even read", d, init_val(8'h24));
  endtask

  task automatic t_read_one();
    logic [7:0] d;
    read_one(8'h05, d);
    check(d == init_val(5), "R4 single-byte read", d, init_val(5));
  endtask

  task automatic t_atomic();
    bit ack; logic [7:0] d0, d1; int r0;
    bus_start(); send_byte(8'hAA, ack); send_byte(8'h10, ack);
    bus_start(); send_byte(8'hAB, ack);
    r0 = rd_count;
    recv_byte(1'b1, d0);
    set_reg(7'h11, ~init_val(8'h11));
    recv_byte(1'b0, d1); bus_stop();
    check(d0 == init_val(8'h10), "R5 even byte", d0, init_val(8'h10));
    check(d1 == init_val(8'h11), "R5 odd byte from snapshot", d1, init_val(8'h11));
    check(rd_count - r0 == 1, "R5 single pair access", rd_count - r0, 1);
  endtask

  task automatic t_wrap();
    bit ack; logic [7:0] d [4];
    bus_start(); send_byte(8'hAA, ack); send_byte(8'h7E, ack);
    bus_start(); send_byte(8'hAB, ack);
    for (int i = 0; i < 4; i++) recv_byte(i != 3, d[i]);
    bus_stop();
    check(d[0] == init_val(8'h7E), "R6 byte 0x7E", d[0], init_val(8'h7E));
    check(d[1] == init_val(8'h7F), "R6 byte 0x7F", d[1], init_val(8'h7F));
    check(d[2] == init_val(0), "R6 wrap to 0x00", d[2], init_val(0));
    check(d[3] == init_val(1), "R6 then 0x01", d[3], init_val(1));
  endtask

  task automatic t_bad_cmd();
    bit a0, a1;
    bus_start(); send_byte(8'hAA, a0); send_byte(8'h80, a1); bus_stop();
    check(a0 && !a1, "R7 command 0x80 NACK", a1, 0);
    bus_start(); send_byte(8'hAA, a0); send_byte(8'hFF, a1); bus_stop();
    check(!a1, "R7 command 0xFF NACK", a1, 0);
  endtask

  task automatic t_readonly();
    bit a0, a1, a2; int w0 = wr_count; logic [7:0] d;
    bus_start(); send_byte(8'hAA, a0); send_byte(8'h40, a1); send_byte(8'h99, a2); bus_stop();
    check(a1 && !a2, "R8 read-only data NACK", a2, 0);
    check(wr_count == w0, "R8 no strobe", wr_count - w0, 0);
    read_one(8'h40, d);
    check(d == init_val(8'h40), "R8 value kept", d, init_val(8'h40));
  endtask

  task automatic t_incr_write();
    bit a0, a1, a2, a3, a4; int w0 = wr_count;
    bus_start(); send_byte(8'hAA, a0); send_byte(8'h30, a1);
    send_byte(8'h11, a2); send_byte(8'h22, a3); send_byte(8'h33, a4); bus_stop();
    check(a2 && !a3 && !a4, "R9 extra bytes NACK", {a2, a3, a4}, 4);
    check(wr_count == w0 + 1, "R9 one write only", wr_count - w0, 1);
    check(mem[8'h31] == init_val(8'h31), "R9 next byte untouched", mem[8'h31], init_val(8'h31));
  endtask

  task automatic t_timeout();
    logic [7:0] d;
    bus_start();
    for (int i = 7; i >= 0; i--) begin
      sda_h = 1'(8'hAA >> i); hold(H);
      scl_h = 1'b1; hold(H);
      scl_h = 1'b0;
    end
    sda_h = 1'b1; hold(H);
    check(sda_oe == 1'b1, "R10 ACK held before timeout", sda_oe, 1);
    hold(STUCK + 40);
    check(sda_oe == 1'b0, "R10 SDA released after timeout", sda_oe, 0);
    scl_h = 1'b1; hold(H);
    read_one(8'h05, d);
    check(d == init_val(5), "R10 recovery read", d, init_val(5));
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    hold(10);
    t_reset();
    rst_n = 1'b1;
    hold(10);
    t_addr_mismatch();
    t_write();
    t_quick_read();
    t_read_one();
    t_atomic();
    t_wrap();
    t_bad_cmd();
    t_readonly();
    t_incr_write();
    t_timeout();
    check(drive_viol == 0, "R11 drive starts with SCL low", drive_viol, 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule